// File: doc/BRIEF.md
# Reservation Station with Broadcast Wakeup

This block keeps a small pool of waiting operations for one class of functional unit in an out-of-order core. Each accepted operation carries:

- an opcode;
- a destination tag, which is the reorder-buffer slot allocated to it;
- two source operands. Each operand arrives either as a finished value or as the reorder-buffer tag of the producer that has not yet finished.

Waiting operands watch a single result bus that carries a valid bit, a tag and a value. Every entry whose pending tag matches the broadcast takes the value in the same cycle. This includes an operation being accepted in that very cycle.

Once both operands of an entry hold values, the entry competes for issue. The oldest competing entry is loaded into a registered issue bundle. The bundle is held until the execution unit raises its ready signal. An issued entry keeps its slot until its own destination tag appears on the result bus. The slot is then released.

A flush empties the pool and the issue register in one cycle. The full flag stops further acceptance while every slot is occupied.

Top module: `rs_station`

## Requirements
- R1: An operation is accepted on a clock edge only when `disp_valid`=1, `rob_free`=1, `full`=0 and `flush`=0. With `rob_free`=0 nothing is stored and nothing later issues.
- R2: A source whose ready bit (`disp_a_rdy`/`disp_b_rdy`) is 1 at acceptance is stored as the value given with it.
- R3: A stored entry whose operand is still pending latches `cdb_val` on the edge where `cdb_valid`=1 and `cdb_tag` equals its pending tag.
- R4: One broadcast wakes every entry, and both operands of an entry, that wait on the same tag in that cycle.
- R5: If the result bus carries a matching tag in the cycle an operation is accepted, the pending source is stored as that bus value and is already ready.
- R6: An entry is issued only after both operands hold values. The issue bundle carries its opcode, destination tag and both operand values, and appears one cycle after the entry became ready at the earliest.
- R7: Among entries ready at the same time, the one accepted earliest is issued first. At most one entry is issued per cycle, and an entry is issued once.
- R8: While `iss_valid`=1 and `exe_ready`=0, the issue bundle holds its contents.
- R9: An issued entry is released when its destination tag is broadcast with `cdb_valid`=1. Its slot can then be reused.
- R10: `full`=1 exactly when every slot is occupied. A dispatch offered while full is ignored.
- R11: `flush`=1 releases every slot and clears `iss_valid` on the next edge.
- R12: After reset `iss_valid`=0 and `full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all slots and the issue register |
| disp_valid | input | 1 | An operation is offered |
| rob_free | input | 1 | A reorder-buffer slot is available for it |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Reorder-buffer slot allocated as destination tag |
| disp_a_rdy | input | 1 | Source A is a value (1) or a pending tag (0) |
| disp_a_tag | input | TAG_W | Producer tag of source A |
| disp_a_val | input | DATA_W | Value of source A |
| disp_b_rdy | input | 1 | Source B is a value (1) or a pending tag (0) |
| disp_b_tag | input | TAG_W | Producer tag of source B |
| disp_b_val | input | DATA_W | Value of source B |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Broadcast result value |
| exe_ready | input | 1 | Execution unit takes the issue bundle |
| iss_valid | output | 1 | Issue bundle valid |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_a | output | DATA_W | Issued operand A value |
| iss_b | output | DATA_W | Issued operand B value |
| full | output | 1 | No free slot |

## Verification
Wakeup is tried in four ways:

- operands that are ready at dispatch, which separates a stored value from a bus capture;
- three entries waiting on one tag that is broadcast once, which exposes a wakeup that reaches only one matching entry;
- a dispatch whose producer result is on the bus in the same cycle, which exposes an entry left waiting forever;
- a long random mix of tags, stalls and flushes, which exposes misordered selection when several entries become ready together.

Filling the pool with operations that never wake separates the full back-pressure from a silently overwritten slot. Dispatches offered with no reorder slot are also tried.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned RS_ENTRIES = 4;
  localparam int unsigned RS_TAG_W   = 3;
  localparam int unsigned RS_DATA_W  = 16;
  localparam int unsigned RS_OP_W    = 4;
  localparam int unsigned RS_AGE_W   = 8;
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AGE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  logic              age_inc,
  input  logic              grant,
  input  logic [OP_W-1:0]   d_op,
  input  logic [TAG_W-1:0]  d_dst,
  input  logic              d_a_rdy,
  input  logic [TAG_W-1:0]  d_a_tag,
  input  logic [DATA_W-1:0] d_a_val,
  input  logic              d_b_rdy,
  input  logic [TAG_W-1:0]  d_b_tag,
  input  logic [DATA_W-1:0] d_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              e_valid,
  output logic              e_ready,
  output logic [AGE_W-1:0]  e_age,
  output logic [OP_W-1:0]   e_op,
  output logic [TAG_W-1:0]  e_dst,
  output logic [DATA_W-1:0] e_a_val,
  output logic [DATA_W-1:0] e_b_val
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic             issued, a_rdy, b_rdy;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic             hit_a, hit_b, hit_da, hit_db, release_now;

  assign hit_a       = cdb_valid && !a_rdy && (cdb_tag == a_tag);
  assign hit_b       = cdb_valid && !b_rdy && (cdb_tag == b_tag);
  assign hit_da      = cdb_valid && (cdb_tag == d_a_tag);
  assign hit_db      = cdb_valid && (cdb_tag == d_b_tag);
  assign release_now = issued && cdb_valid && (cdb_tag == e_dst);
  assign e_ready     = e_valid && a_rdy && b_rdy && !issued;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      e_valid <= 1'b0;
      issued  <= 1'b0;
      a_rdy   <= 1'b0;
      b_rdy   <= 1'b0;
    end else if (alloc) begin
      e_valid <= 1'b1;
      issued  <= 1'b0;
      e_op    <= d_op;
      e_dst   <= d_dst;
      e_age   <= '0;
      a_tag   <= d_a_tag;
      b_tag   <= d_b_tag;
      a_rdy   <= d_a_rdy || hit_da;
      b_rdy   <= d_b_rdy || hit_db;
      e_a_val <= d_a_rdy ? d_a_val : cdb_val;
      e_b_val <= d_b_rdy ? d_b_val : cdb_val;
    end else if (e_valid) begin
      if (release_now) begin
        e_valid <= 1'b0;
        issued  <= 1'b0;
      end else if (grant) begin
        issued <= 1'b1;
      end
      if (hit_a) begin
        a_rdy   <= 1'b1;
        e_a_val <= cdb_val;
      end
      if (hit_b) begin
        b_rdy   <= 1'b1;
        e_b_val <= cdb_val;
      end
      if (age_inc && e_age != AGE_MAX) e_age <= e_age + 1'b1;
    end
  end

  // Capture of a broadcast by a waiting operand
  assert_wakeup_a_R3: assert property (@(posedge clk) disable iff (rst)
    (e_valid && !flush && !alloc && !a_rdy && cdb_valid && cdb_tag == a_tag)
      |=> (a_rdy && e_a_val == $past(cdb_val)));
  assert_wakeup_b_R4: assert property (@(posedge clk) disable iff (rst)
    (e_valid && !flush && !alloc && !b_rdy && cdb_valid && cdb_tag == b_tag)
      |=> (b_rdy && e_b_val == $past(cdb_val)));
  // An entry marked as issued had both values
  assert_issue_ready_R6: assert property (@(posedge clk) disable iff (rst)
    issued |-> (a_rdy && b_rdy && e_valid));
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned N     = 4,
  parameter int unsigned AGE_W = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][AGE_W-1:0] age,
  output logic                    sel_valid,
  output logic [IDX_W-1:0]        sel_idx
);
  logic [AGE_W-1:0] best;
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    best      = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!sel_valid || age[i] > best)) begin
        sel_valid = 1'b1;
        sel_idx   = IDX_W'(i);
        best      = age[i];
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int unsigned NUM_ENT = rs_pkg::RS_ENTRIES,
  parameter int unsigned TAG_W   = rs_pkg::RS_TAG_W,
  parameter int unsigned DATA_W  = rs_pkg::RS_DATA_W,
  parameter int unsigned OP_W    = rs_pkg::RS_OP_W,
  parameter int unsigned AGE_W   = rs_pkg::RS_AGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              disp_valid,
  input  logic              rob_free,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic              disp_a_rdy,
  input  logic [TAG_W-1:0]  disp_a_tag,
  input  logic [DATA_W-1:0] disp_a_val,
  input  logic              disp_b_rdy,
  input  logic [TAG_W-1:0]  disp_b_tag,
  input  logic [DATA_W-1:0] disp_b_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  input  logic              exe_ready,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_dst,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b,
  output logic              full
);
  localparam int unsigned IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0]             ent_valid, ent_ready, alloc_vec, grant_vec;
  logic [NUM_ENT-1:0][AGE_W-1:0]  ent_age;
  logic [NUM_ENT-1:0][OP_W-1:0]   ent_op;
  logic [NUM_ENT-1:0][TAG_W-1:0]  ent_dst;
  logic [NUM_ENT-1:0][DATA_W-1:0] ent_a, ent_b;
  logic                           accept, load, sel_valid, slot_found;
  logic [IDX_W-1:0]               sel_idx, slot_idx;

  assign full   = &ent_valid;
  assign accept = disp_valid && rob_free && !full && !flush;
  assign load   = !flush && (!iss_valid || exe_ready);

  // Lowest-numbered free slot takes the next accepted operation
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!ent_valid[i] && !slot_found) begin
        slot_found = 1'b1;
        slot_idx   = IDX_W'(i);
      end
    end
  end

  rs_select #(.N(NUM_ENT), .AGE_W(AGE_W)) u_sel (
    .cand(ent_ready), .age(ent_age), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign alloc_vec[g] = accept && (slot_idx == IDX_W'(g));
    assign grant_vec[g] = load && sel_valid && (sel_idx == IDX_W'(g));
    rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) u_ent (
      .clk(clk), .rst(rst), .flush(flush),
      .alloc(alloc_vec[g]), .age_inc(accept), .grant(grant_vec[g]),
      .d_op(disp_op), .d_dst(disp_dst),
      .d_a_rdy(disp_a_rdy), .d_a_tag(disp_a_tag), .d_a_val(disp_a_val),
      .d_b_rdy(disp_b_rdy), .d_b_tag(disp_b_tag), .d_b_val(disp_b_val),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
      .e_valid(ent_valid[g]), .e_ready(ent_ready[g]), .e_age(ent_age[g]),
      .e_op(ent_op[g]), .e_dst(ent_dst[g]), .e_a_val(ent_a[g]), .e_b_val(ent_b[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      iss_valid <= 1'b0;
    end else if (load) begin
      iss_valid <= sel_valid;
      iss_op    <= ent_op[sel_idx];
      iss_dst   <= ent_dst[sel_idx];
      iss_a     <= ent_a[sel_idx];
      iss_b     <= ent_b[sel_idx];
    end
  end

  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));
  assert_grant_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (|grant_vec) |-> (|(grant_vec & ent_ready)));
  assert_hold_bundle_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !exe_ready && !flush)
      |=> (iss_valid && $stable(iss_a) && $stable(iss_b) && $stable(iss_dst)));
  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!iss_valid && !full));
  assert_no_store_full_R10: assert property (@(posedge clk) disable iff (rst)
    (full && !cdb_valid && !flush) |=> full);
endmodule

// File: tb/rs_station_tb.sv
`timescale 1ns/1ps
module rs_station_tb;
  localparam int N = 4;

  logic clk = 0, rst = 1, flush = 0;
  logic disp_valid = 0, rob_free = 1;
  logic [3:0]  disp_op = 0;
  logic [2:0]  disp_dst = 0, disp_a_tag = 0, disp_b_tag = 0, cdb_tag = 0;
  logic        disp_a_rdy = 0, disp_b_rdy = 0, cdb_valid = 0, exe_ready = 1;
  logic [15:0] disp_a_val = 0, disp_b_val = 0, cdb_val = 0;
  logic        iss_valid, full;
  logic [3:0]  iss_op;
  logic [2:0]  iss_dst;
  logic [15:0] iss_a, iss_b;

  always #10 clk = ~clk;

  rs_station u_dut (
    .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid), .rob_free(rob_free),
    .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val), .exe_ready(exe_ready),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst), .iss_a(iss_a),
    .iss_b(iss_b), .full(full)
  );

  // Reference model state
  bit          mv[N], mi[N], mar[N], mbr[N];
  logic [2:0]  mat[N], mbt[N], mdst[N];
  logic [3:0]  mop[N];
  logic [15:0] mav[N], mbv[N];
  int          mseq[N];
  int          seq_ctr = 0;
  bit          miv = 0;
  logic [3:0]  miop;
  logic [2:0]  midst;
  logic [15:0] mia, mib;
  int          n_cmp = 0, n_bad = 0;
  string       cur_req = "R12";

  task automatic model_step();
    bit fullm = 1; bit acc, ld; int slot = -1, sel = -1;
    for (int i = 0; i < N; i++) if (!mv[i]) fullm = 0;
    acc = disp_valid && rob_free && !fullm && !flush;
    for (int i = 0; i < N; i++) if (!mv[i] && slot < 0) slot = i;
    for (int i = 0; i < N; i++)
      if (mv[i] && !mi[i] && mar[i] && mbr[i] && (sel < 0 || mseq[i] < mseq[sel])) sel = i;
    ld = !flush && (!miv || exe_ready);
    if (rst || flush) begin
      for (int i = 0; i < N; i++) begin mv[i] = 0; mi[i] = 0; end
      miv = 0;
    end else begin
      if (ld) begin
        miv = (sel >= 0);
        if (sel >= 0) begin miop = mop[sel]; midst = mdst[sel]; mia = mav[sel]; mib = mbv[sel]; end
      end
      for (int i = 0; i < N; i++) if (mv[i]) begin
        if (mi[i] && cdb_valid && cdb_tag == mdst[i]) begin mv[i] = 0; mi[i] = 0; end
        else if (ld && i == sel) mi[i] = 1;
        if (!mar[i] && cdb_valid && cdb_tag == mat[i]) begin mar[i] = 1; mav[i] = cdb_val; end
        if (!mbr[i] && cdb_valid && cdb_tag == mbt[i]) begin mbr[i] = 1; mbv[i] = cdb_val; end
      end
      if (acc) begin
        mv[slot] = 1; mi[slot] = 0; mop[slot] = disp_op; mdst[slot] = disp_dst;
        mat[slot] = disp_a_tag; mbt[slot] = disp_b_tag; mseq[slot] = seq_ctr; seq_ctr++;
        mar[slot] = disp_a_rdy || (cdb_valid && cdb_tag == disp_a_tag);
        mbr[slot] = disp_b_rdy || (cdb_valid && cdb_tag == disp_b_tag);
        mav[slot] = disp_a_rdy ? disp_a_val : cdb_val;
        mbv[slot] = disp_b_rdy ? disp_b_val : cdb_val;
      end
    end
  endtask

  task automatic compare();
    bit fullm = 1;
    for (int i = 0; i < N; i++) if (!mv[i]) fullm = 0;
    n_cmp++;
    if (iss_valid !== miv || full !== fullm ||
        (miv && (iss_op !== miop || iss_dst !== midst || iss_a !== mia || iss_b !== mib))) begin
      n_bad++;
      $display("FAIL %s: actual v=%0b full=%0b op=%h dst=%h a=%h b=%h expected v=%0b full=%0b op=%h dst=%h a=%h b=%h",
               cur_req, iss_valid, full, iss_op, iss_dst, iss_a, iss_b,
               miv, fullm, miop, midst, mia, mib);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    compare();
    disp_valid = 0; cdb_valid = 0; flush = 0; rst = 0;
  endtask

  task automatic disp(input logic [3:0] op, input logic [2:0] dst,
                      input logic ar, input logic [2:0] at, input logic [15:0] av,
                      input logic br, input logic [2:0] bt, input logic [15:0] bv);
    disp_valid = 1; disp_op = op; disp_dst = dst;
    disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
    disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [15:0] v);
    cdb_valid = 1; cdb_tag = t; cdb_val = v;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #5; rst = 1; tick(); tick();
    cur_req = "R12"; tick();
    // R1: no reorder slot, offer ignored
    cur_req = "R1"; rob_free = 0; disp(4'h9, 3'd0, 1, 0, 16'h1111, 1, 0, 16'h2222); tick();
    rob_free = 1; tick(); tick();
    // R2 / R6: both values at dispatch
    cur_req = "R2_R6"; disp(4'h1, 3'd1, 1, 0, 16'h000A, 1, 0, 16'h0014); tick();
    tick(); tick();
    cur_req = "R9"; bcast(3'd1, 16'h0); tick(); tick();
    // R3 / R4: three entries wait on tag 5
    cur_req = "R4"; disp(4'h2, 3'd2, 0, 3'd5, 0, 1, 0, 16'h0002); tick();
    disp(4'h3, 3'd3, 0, 3'd5, 0, 1, 0, 16'h0003); tick();
    disp(4'h4, 3'd4, 0, 3'd5, 0, 0, 3'd5, 0); tick();
    cur_req = "R3"; tick();
    bcast(3'd5, 16'h0055); tick();
    cur_req = "R7"; for (int k = 0; k < 5; k++) tick();
    cur_req = "R9"; bcast(3'd2, 0); tick(); bcast(3'd3, 0); tick(); bcast(3'd4, 0); tick(); tick();
    // R5: producer result on the bus in the dispatch cycle
    cur_req = "R5"; disp(4'h5, 3'd6, 0, 3'd6, 0, 1, 0, 16'h0777); bcast(3'd6, 16'h0066); tick();
    tick(); tick(); bcast(3'd6, 0); tick();
    // R10: fill with never-woken entries, then one more offer
    cur_req = "R10";
    for (int k = 0; k < 5; k++) begin disp(4'(k), 3'(k), 0, 3'd7, 0, 1, 0, 16'(k)); tick(); end
    tick();
    // R11
    cur_req = "R11"; flush = 1; tick(); tick();
    // R8: execution unit stalls
    cur_req = "R8"; exe_ready = 0;
    disp(4'hA, 3'd0, 1, 0, 16'hAAAA, 1, 0, 16'h0A0A); tick();
    disp(4'hB, 3'd1, 1, 0, 16'hBBBB, 1, 0, 16'h0B0B); tick();
    for (int k = 0; k < 4; k++) tick();
    exe_ready = 1; tick(); tick(); tick();
    cur_req = "R11"; flush = 1; tick();
    // Random mix (R7 ordering among simultaneous wakeups)
    cur_req = "R7_random";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 1) == 1)
        disp(4'($urandom), 3'($urandom), 1'($urandom_range(0, 3) == 0), 3'($urandom),
             16'($urandom), 1'($urandom_range(0, 1)), 3'($urandom), 16'($urandom));
      if ($urandom_range(0, 2) != 0) bcast(3'($urandom), 16'($urandom));
      exe_ready = ($urandom_range(0, 3) != 0);
      rob_free  = ($urandom_range(0, 7) != 0);
      if (k % 250 == 249) flush = 1;
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule